// File: doc/BRIEF.md
# Compressed Branch Trace Buffer

This block keeps a compact on-chip history of a processor's control flow in 256 bytes of storage. Each cycle it sees four event inputs: an instruction retired, a direct branch taken, an indirect branch taken (with its 32-bit target), and an exception taken. It does not store every instruction. It writes a one-byte message only when control flow changes. That byte carries the kind of change and how many instructions retired since the previous message. An indirect branch adds its target address as four further bytes. When the running instruction count cannot fit in four bits, a roll-over byte is written and the count starts again.

Software chooses between two modes. Wraparound mode keeps the newest 256 bytes. Fill-once mode records until the next message would not fit and then raises a buffer-full break. The buffer is read one byte per strobe, oldest first. Every read clears the byte it returns. After 256 reads the buffer is empty and recording starts afresh.

A three-state controller sequences the block:
- ST_IDLE: tracing is off and reads are served. It moves to ST_REC when enable rises.
- ST_REC: messages are recorded. It returns to ST_IDLE when enable falls, and moves to ST_FULL on a fill-once overflow.
- ST_FULL: recording is halted and the break is raised. It returns to ST_IDLE on the 256th read.

Top module: `trc_buffer`

## Requirements
- R1: After reset, full_brk is 0, rd_data is 0 and the buffer is empty, so a full readout returns 256 zero bytes.
- R2: A message byte holds the type in bits 7:4 and the count in bits 3:0. The types are 0x0 for an exception, 0x8 for a direct branch and 0x9 for an indirect branch. The count is the number of instructions retired since the previous message, and it includes an instruction retired in the message's own cycle.
- R3: An indirect-branch message is followed at once by the 32-bit target, least-significant byte first, for five bytes in total.
- R4: If a retire arrives while the count is 15, a roll-over byte 0xF0 is written and the count restarts at 0. If a branch or exception arrives in the same cycle, the roll-over byte comes first and the event message carries count 0.
- R5: At most one control-flow message is written per cycle, with priority exception over indirect branch over direct branch. An exception never appends target bytes.
- R6: In wraparound mode (fill_once = 0) recording never stops and full_brk stays 0. A readout returns the newest 256 bytes, oldest first.
- R7: In fill-once mode (fill_once = 1), a message (including any roll-over byte) that would take the stored total past 256 bytes is not written at all. full_brk then rises on the next cycle and holds. No further events are recorded until the buffer has been drained.
- R8: A read strobe is accepted in ST_IDLE with trace_en low, or in ST_FULL. rd_data shows the byte one cycle later. Bytes come oldest first, each read clears its byte, and reads past the recorded bytes return 0.
- R9: The 256th accepted read empties the buffer and drops full_brk. The next recording starts at the head of a fresh buffer.
- R10: While trace_en is low, events are not recorded and the instruction count is cleared. A read strobe while recording leaves rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Enables recording |
| fill_once | input | 1 | 1 selects fill-once mode, 0 selects wraparound |
| retire | input | 1 | One instruction retired this cycle |
| br_direct | input | 1 | Direct branch taken this cycle |
| br_indirect | input | 1 | Indirect branch taken this cycle |
| br_target | input | 32 | Target address of the indirect branch |
| exc_taken | input | 1 | Exception taken this cycle |
| rd_en | input | 1 | Read strobe: consume one byte |
| rd_data | output | 8 | Byte returned by the last accepted read |
| full_brk | output | 1 | Buffer-full break, fill-once mode only |

## Verification
The bench builds the block with its default values: 256 bytes of storage and a 32-bit target, so each indirect message takes five bytes. At these values a run of 60 indirect messages (300 bytes) wraps the write pointer and moves the oldest byte into the middle of storage. In the same way, 51 indirect messages leave exactly one free byte, so the next five-byte message is the overflow case in fill-once mode. Every drain is a full 256-read readout, which exercises both the zero tail and the pointer reset.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int TYPE_W = 4;
    localparam int CNT_W  = 4;

    localparam logic [TYPE_W-1:0] TY_EXC  = 4'h0;
    localparam logic [TYPE_W-1:0] TY_DIR  = 4'h8;
    localparam logic [TYPE_W-1:0] TY_IND  = 4'h9;
    localparam logic [TYPE_W-1:0] TY_ROLL = 4'hF;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REC,
        ST_FULL
    } trc_state_e;
endpackage

// File: rtl/trc_encoder.sv
module trc_encoder
    import trc_pkg::*;
#(
    parameter int TGT_W = 32,
    localparam int TB   = TGT_W / 8,
    localparam int MAXB = TB + 2,
    localparam int NB_W = $clog2(MAXB + 1)
) (
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              retire,
    input  logic              exc,
    input  logic              ind,
    input  logic              dir,
    input  logic [TGT_W-1:0]  target,
    output byte_t [MAXB-1:0]  msg_bytes,
    output logic [NB_W-1:0]   msg_len,
    output logic [CNT_W-1:0]  cnt_d
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              ev;
    logic              is_ind;
    logic              roll;
    logic [TYPE_W-1:0] ty;
    logic [CNT_W-1:0]  mcnt;
    byte_t [MAXB-1:0]  ev_b;

    always_comb begin
        ev     = exc | ind | dir;
        is_ind = ind && !exc;
        ty     = exc ? TY_EXC : (is_ind ? TY_IND : TY_DIR);
        roll   = retire && (cnt_q == CNT_MAX);
        mcnt   = roll ? '0 : cnt_q + CNT_W'(retire);

        ev_b = '0;
        if (ev) begin
            ev_b[0] = {ty, mcnt};
            if (is_ind) begin
                for (int i = 0; i < TB; i++) begin
                    ev_b[1 + i] = target[8*i +: 8];
                end
            end
        end

        // roll-over byte always precedes the event message
        msg_bytes = roll ? {ev_b[MAXB-2:0], {TY_ROLL, {CNT_W{1'b0}}}} : ev_b;

        msg_len = NB_W'(roll)
                + (ev ? (is_ind ? NB_W'(TB + 1) : NB_W'(1)) : NB_W'(0));

        cnt_d = (ev || roll) ? '0 : cnt_q + CNT_W'(retire);
    end
endmodule

// File: rtl/trc_store.sv
module trc_store
    import trc_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int MAXB  = 6,
    localparam int AW   = $clog2(DEPTH),
    localparam int NB_W = $clog2(MAXB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_ptr,
    input  byte_t [MAXB-1:0] wr_bytes,
    input  logic [NB_W-1:0]  wr_len,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output byte_t            rd_data
);
    byte_t mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rd_data <= '0;
        end else begin
            if (wr_en) begin
                for (int k = 0; k < MAXB; k++) begin
                    if (NB_W'(k) < wr_len) begin
                        mem[wr_ptr + AW'(k)] <= wr_bytes[k];
                    end
                end
            end
            if (rd_en) begin
                rd_data      <= mem[rd_addr];
                mem[rd_addr] <= '0;
            end
        end
    end

    // a write and a destructive read must never share a cycle
    assert_rw_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
endmodule

// File: rtl/trc_buffer.sv
module trc_buffer
    import trc_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int TGT_W = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1,
    localparam int TB   = TGT_W / 8,
    localparam int MAXB = TB + 2,
    localparam int NB_W = $clog2(MAXB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trace_en,
    input  logic             fill_once,
    input  logic             retire,
    input  logic             br_direct,
    input  logic             br_indirect,
    input  logic [TGT_W-1:0] br_target,
    input  logic             exc_taken,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             full_brk
);
    trc_state_e state_q, state_d;

    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rcnt_q;
    logic [LW-1:0]    level_q;
    logic [CNT_W-1:0] cnt_q;

    byte_t [MAXB-1:0] enc_bytes;
    logic [NB_W-1:0]  enc_len;
    logic [CNT_W-1:0] enc_cnt;

    logic [LW:0]      lvl_sum;
    logic             fits;
    logic             wr_go, ovf, rd_go, drain_done;
    logic [AW-1:0]    rd_addr;

    trc_encoder #(.TGT_W(TGT_W)) u_enc (
        .cnt_q    (cnt_q),
        .retire   (retire),
        .exc      (exc_taken),
        .ind      (br_indirect),
        .dir      (br_direct),
        .target   (br_target),
        .msg_bytes(enc_bytes),
        .msg_len  (enc_len),
        .cnt_d    (enc_cnt)
    );

    assign lvl_sum = {1'b0, level_q} + (LW+1)'(enc_len);
    assign fits    = lvl_sum <= (LW+1)'(DEPTH);
    assign rd_addr = ((level_q == LW'(DEPTH)) ? wr_ptr_q : '0) + rcnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions and control outputs
    always_comb begin
        state_d = state_q;
        wr_go   = 1'b0;
        ovf     = 1'b0;
        rd_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                rd_go = rd_en && !trace_en;
                if (trace_en) state_d = ST_REC;
            end
            ST_REC: begin
                if (!trace_en) begin
                    state_d = ST_IDLE;
                end else if (enc_len != '0 && fill_once && !fits) begin
                    ovf     = 1'b1;
                    state_d = ST_FULL;
                end else begin
                    wr_go = enc_len != '0;
                end
            end
            ST_FULL: rd_go = rd_en;
            default: state_d = ST_IDLE;
        endcase
        drain_done = rd_go && (rcnt_q == AW'(DEPTH - 1));
        if (drain_done && state_q == ST_FULL) state_d = ST_IDLE;
    end

    assign full_brk = (state_q == ST_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            level_q  <= '0;
            rcnt_q   <= '0;
            cnt_q    <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
            end else if (state_q == ST_REC && trace_en && !ovf) begin
                cnt_q <= enc_cnt;
            end
            if (wr_go) begin
                wr_ptr_q <= wr_ptr_q + AW'(enc_len);
                level_q  <= fits ? lvl_sum[LW-1:0] : LW'(DEPTH);
            end
            if (state_q == ST_REC) rcnt_q <= '0;
            else if (rd_go)        rcnt_q <= rcnt_q + 1'b1;
            if (drain_done) begin
                wr_ptr_q <= '0;
                level_q  <= '0;
            end
        end
    end

    trc_store #(.DEPTH(DEPTH), .MAXB(MAXB)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_go),
        .wr_ptr  (wr_ptr_q),
        .wr_bytes(enc_bytes),
        .wr_len  (enc_len),
        .rd_en   (rd_go),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assert_level_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH));

    assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_brk && !drain_done) |=> full_brk);

    assert_full_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_brk) |-> $past(fill_once));

    assert_drain_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |=> (level_q == '0 && !full_brk));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REC) |=> $stable(rd_data));
endmodule

// File: tb/trc_buffer_test.sv
module trc_buffer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        fill_once = 1'b0;
    logic        retire = 1'b0;
    logic        br_direct = 1'b0;
    logic        br_indirect = 1'b0;
    logic [31:0] br_target = '0;
    logic        exc_taken = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        full_brk;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    trc_buffer uut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .fill_once(fill_once),
        .retire(retire), .br_direct(br_direct), .br_indirect(br_indirect),
        .br_target(br_target), .exc_taken(exc_taken), .rd_en(rd_en),
        .rd_data(rd_data), .full_brk(full_brk)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic ev(bit r, bit d, bit i, bit e, logic [31:0] t);
        retire = r; br_direct = d; br_indirect = i; exc_taken = e; br_target = t;
        @(negedge clk);
        retire = 0; br_direct = 0; br_indirect = 0; exc_taken = 0; br_target = '0;
    endtask

    task automatic retire_n(int n);
        for (int k = 0; k < n; k++) ev(1, 0, 0, 0, '0);
    endtask

    task automatic push_ind(logic [3:0] c, logic [31:0] t);
        exp_q.push_back({4'h9, c});
        for (int k = 0; k < 4; k++) exp_q.push_back(t[8*k +: 8]);
    endtask

    task automatic start_rec(bit fill);
        fill_once = fill; trace_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop_rec();
        trace_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain(string tag);
        logic [7:0] e;
        rd_en = 1'b1;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else                  e = 8'h00;
            check8(tag, rd_data, e);
        end
        rd_en = 1'b0;
        exp_q.delete();
    endtask

    task automatic t_reset();
        check1("R1 full_brk", full_brk, 1'b0);
        check8("R1 rd_data", rd_data, 8'h00);
        drain("R1 empty");
    endtask

    task automatic t_basic();
        start_rec(0);
        retire_n(3);
        ev(1, 1, 0, 0, '0);          // 3+1 -> 0x84
        retire_n(2);
        ev(0, 0, 0, 1, '0);          // exception, 2 -> 0x02
        ev(0, 1, 0, 0, '0);          // direct, 0 -> 0x80
        stop_rec();
        exp_q = '{8'h84, 8'h02, 8'h80};
        drain("R2");
    endtask

    task automatic t_indirect();
        start_rec(0);
        ev(1, 0, 1, 0, 32'hDEADBEEF);
        ev(0, 0, 1, 0, 32'h12345678);
        stop_rec();
        push_ind(4'h1, 32'hDEADBEEF);
        push_ind(4'h0, 32'h12345678);
        drain("R3");
    endtask

    task automatic t_rollover();
        start_rec(0);
        retire_n(16);                // 16th retire -> 0xF0
        retire_n(3);
        ev(0, 1, 0, 0, '0);          // 0x83
        retire_n(15);
        ev(1, 0, 0, 1, '0);          // 0xF0 then 0x00
        stop_rec();
        exp_q = '{8'hF0, 8'h83, 8'hF0, 8'h00};
        drain("R4");
    endtask

    task automatic t_priority();
        start_rec(0);
        ev(1, 1, 1, 1, 32'h55AA55AA); // exception wins, 0x01
        ev(0, 1, 1, 0, 32'hCAFEF00D); // indirect over direct
        ev(0, 0, 1, 1, 32'h11111111); // exception, no target bytes
        stop_rec();
        exp_q.push_back(8'h01);
        push_ind(4'h0, 32'hCAFEF00D);
        exp_q.push_back(8'h00);
        drain("R5");
    endtask

    task automatic t_wrap();
        logic [7:0]  all_q[$];
        logic [31:0] t;
        start_rec(0);
        for (int i = 0; i < 60; i++) begin
            t = 32'h10203040 + i * 32'h01030507;
            ev(i[0], 0, 1, 0, t);
            all_q.push_back({4'h9, 3'b000, i[0]});
            for (int k = 0; k < 4; k++) all_q.push_back(t[8*k +: 8]);
        end
        check1("R6 no break", full_brk, 1'b0);
        stop_rec();
        for (int k = 44; k < 300; k++) exp_q.push_back(all_q[k]);
        drain("R6");
    endtask

    task automatic t_disabled();
        logic [7:0] prev;
        prev = rd_data;
        start_rec(0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check8("R10 read ignored", rd_data, prev);
        retire_n(3);
        stop_rec();
        retire_n(2);
        ev(1, 1, 0, 0, '0);          // not recorded
        start_rec(0);
        ev(0, 1, 0, 0, '0);          // count cleared -> 0x80
        stop_rec();
        exp_q = '{8'h80};
        drain("R10");
    endtask

    task automatic t_fill();
        logic [31:0] t;
        start_rec(1);
        for (int i = 0; i < 51; i++) begin
            t = 32'hA0000001 + i * 32'h00010203;
            ev(0, 0, 1, 0, t);
            push_ind(4'h0, t);
        end
        check1("R7 no early break", full_brk, 1'b0);
        ev(0, 0, 1, 0, 32'hFFFFFFFF); // does not fit
        check1("R7 break raised", full_brk, 1'b1);
        ev(0, 1, 0, 0, '0);           // ignored while full
        stop_rec();
        check1("R7 break held", full_brk, 1'b1);
        drain("R7");
        check1("R9 break cleared", full_brk, 1'b0);
    endtask

    task automatic t_fresh();
        start_rec(0);
        retire_n(2);
        ev(0, 1, 0, 0, '0);          // 0x82 at buffer head
        stop_rec();
        exp_q = '{8'h82};
        drain("R9 R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_indirect();
        t_rollover();
        t_priority();
        t_wrap();
        t_disabled();
        t_fill();
        t_fresh();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (R1..all): actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule